// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block holds the interrupt bookkeeping for a secure-module host interface that is shared by five privilege localities. Each locality owns a 32-bit enable word and a 32-bit status word. A single interrupt line is shared by all of them. Event logic elsewhere in the interface reports four kinds of event as single-cycle pulses, each tagged with the locality it concerns. This unit decides whether a pulse is recorded and whether the line rises.

Software reaches the words through a small register window selected by a byte offset and a locality number. The window holds the enable word, the status word, a hard-wired vector word and a constant capability word. Status bits are cleared by writing 1 to them. Enable and status writes are accepted only from the locality that currently owns the interface. Reads are combinational and are open to every locality. The block does not produce events and does not model the system-side interrupt controller.

Top module: `tis_irq_unit`

## Requirements
- R1: After reset every enable word reads 0x00000008 (polarity field bits 4:3 = 01, low level), every status word reads 0 and `irq` is low.
- R2: An event pulse sets status bits only if the tagged locality's enable word has bit 31 (global) and the matching per-event bit set. The event input `ev_mask` maps bit 0 to status bit 0 (data available), bit 1 to bit 1 (status valid), bit 2 to bit 2 (locality changed) and bit 3 to bit 7 (command ready).
- R3: `irq` is high in the cycle after any event is recorded and stays high until it is lowered as described in R4.
- R4: Writing 1s to status bits 0, 1, 2 or 7 clears those bits. If such a write clears at least one set bit and leaves the writer's status word at zero, `irq` goes low the next cycle, unless an event is recorded in that same cycle.
- R5: Enable and status writes are ignored when no locality is active, or when the write's locality differs from `act_loc`.
- R6: An enable write stores only bit 31, bits 4:3 and bits 7, 2, 1, 0. Writing 0xFFFFFFFF reads back as 0x8000009F.
- R7: Offset 0x14 reads the constant 0x20000697: version 010 in bits 30:28, 64-byte transfer code 11 in bits 10:9, bit 8 = 0, low-level interrupt bit 4, and the supported event bits.
- R8: Offset 0x0C reads `IRQ_NUM` (0 to 15). Writes to it have no effect.
- R9: Offsets other than 0x08, 0x0C, 0x10 and 0x14, and locality numbers of `NUM_LOC` or above, read as 0xFFFFFFFF.
- R10: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_vld | input | 1 | Some locality currently owns the interface |
| act_loc | input | 3 | Number of the owning locality |
| ev_mask | input | 4 | Event pulses: data available, status valid, locality changed, command ready |
| ev_loc | input | 3 | Locality the event pulses concern |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | 3 | Locality issuing the write |
| wr_off | input | 8 | Register byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_loc | input | 3 | Locality of the read |
| rd_off | input | 8 | Register byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Shared interrupt line, active high |

## Verification
A status bit latched without its enables, or lost to a same-cycle clear, shows on the status readback one cycle after the pulse. A line flop out of step with the status words is visible right away as `irq` staying high after the last bit is cleared, or staying low after a recorded event. A faulty ownership or write-mask decode corrupts the enable word, and the corruption appears on the next read. It also shows later as events that are wrongly latched or wrongly dropped.

// File: rtl/tis_irq_pkg.sv
package tis_irq_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned OFF_W = 8;
    localparam int unsigned LOC_W = 3;
    localparam int unsigned N_EV  = 4;

    localparam logic [OFF_W-1:0] OFF_IEN  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_IVEC = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_ISTS = 8'h10;
    localparam logic [OFF_W-1:0] OFF_ICAP = 8'h14;

    localparam int unsigned GLOBAL_BIT = 31;

    localparam logic [DW-1:0] EV_SUPPORTED = 32'h0000_0087;
    localparam logic [DW-1:0] POL_FIELD    = 32'h0000_0018;
    localparam logic [DW-1:0] IEN_WRITABLE = (32'h1 << GLOBAL_BIT) | POL_FIELD | EV_SUPPORTED;
    localparam logic [DW-1:0] IEN_RESET    = 32'h0000_0008;
    localparam logic [DW-1:0] ALL_ONES     = '1;

    localparam logic [DW-1:0] CAP_VERSION  = 32'd2 << 28;
    localparam logic [DW-1:0] CAP_XFER64   = 32'd3 << 9;
    localparam logic [DW-1:0] CAP_LOWLEVEL = 32'd1 << 4;
    localparam logic [DW-1:0] CAP_VALUE    = CAP_VERSION | CAP_XFER64 | CAP_LOWLEVEL | EV_SUPPORTED;

    typedef enum logic [2:0] {
        RSEL_IEN,
        RSEL_IVEC,
        RSEL_ISTS,
        RSEL_ICAP,
        RSEL_NONE
    } rsel_e;

    typedef struct packed {
        logic             en;
        logic [LOC_W-1:0] loc;
        logic [OFF_W-1:0] off;
        logic [DW-1:0]    data;
    } wr_req_t;

    function automatic rsel_e decode_off(input logic [OFF_W-1:0] off);
        case (off)
            OFF_IEN:  return RSEL_IEN;
            OFF_IVEC: return RSEL_IVEC;
            OFF_ISTS: return RSEL_ISTS;
            OFF_ICAP: return RSEL_ICAP;
            default:  return RSEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] ev_to_sts(input logic [N_EV-1:0] ev);
        logic [DW-1:0] r;
        r      = '0;
        r[0]   = ev[0];
        r[1]   = ev[1];
        r[2]   = ev[2];
        r[7]   = ev[3];
        return r;
    endfunction

endpackage

// File: rtl/tis_irq_loc_regs.sv
module tis_irq_loc_regs
    import tis_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ien,
    input  logic          wr_ists,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] ev_bits,
    output logic [DW-1:0] ien_q,
    output logic [DW-1:0] ists_q,
    output logic          raise,
    output logic          lower
);

    logic [DW-1:0] set_bits;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] ists_d;
    logic [DW-1:0] ien_d;

    always_comb begin
        set_bits = ien_q[GLOBAL_BIT] ? (ev_bits & ien_q & EV_SUPPORTED) : '0;
        clr_bits = wr_ists ? (wr_data & EV_SUPPORTED) : '0;
        ists_d   = (ists_q & ~clr_bits) | set_bits;
        ien_d    = wr_ien ? (wr_data & IEN_WRITABLE) : ien_q;
        raise    = |set_bits;
        lower    = (|(clr_bits & ists_q)) && (ists_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= IEN_RESET;
            ists_q <= '0;
        end else begin
            ien_q  <= ien_d;
            ists_q <= ists_d;
        end
    end

endmodule

// File: rtl/tis_irq_line.sv
module tis_irq_line #(
    parameter int unsigned NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LOC-1:0] raise_vec,
    input  logic [NUM_LOC-1:0] lower_vec,
    output logic               irq_q
);

    logic irq_d;

    always_comb begin
        if (|raise_vec)      irq_d = 1'b1;
        else if (|lower_vec) irq_d = 1'b0;
        else                 irq_d = irq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

endmodule

// File: rtl/tis_irq_rd_mux.sv
module tis_irq_rd_mux
    import tis_irq_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned IRQ_NUM = 5
) (
    input  logic [LOC_W-1:0]            rd_loc,
    input  logic [OFF_W-1:0]            rd_off,
    input  logic [NUM_LOC-1:0][DW-1:0]  ien_all,
    input  logic [NUM_LOC-1:0][DW-1:0]  ists_all,
    output logic [DW-1:0]               rd_data
);

    localparam logic [LOC_W-1:0] LOC_MAX = LOC_W'(NUM_LOC - 1);
    localparam logic [DW-1:0]    VEC_VAL = DW'(IRQ_NUM);

    rsel_e         sel;
    logic [DW-1:0] ien_sel;
    logic [DW-1:0] ists_sel;

    always_comb begin
        ien_sel  = '0;
        ists_sel = '0;
        for (int l = 0; l < NUM_LOC; l++) begin
            if (rd_loc == LOC_W'(l)) begin
                ien_sel  = ien_all[l];
                ists_sel = ists_all[l];
            end
        end
        sel = decode_off(rd_off);
        if (rd_loc > LOC_MAX) begin
            rd_data = ALL_ONES;
        end else begin
            case (sel)
                RSEL_IEN:  rd_data = ien_sel;
                RSEL_ISTS: rd_data = ists_sel;
                RSEL_IVEC: rd_data = VEC_VAL;
                RSEL_ICAP: rd_data = CAP_VALUE;
                default:   rd_data = ALL_ONES;
            endcase
        end
    end

endmodule

// File: rtl/tis_irq_unit.sv
module tis_irq_unit
    import tis_irq_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned IRQ_NUM = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_vld,
    input  logic [LOC_W-1:0] act_loc,
    input  logic [N_EV-1:0]  ev_mask,
    input  logic [LOC_W-1:0] ev_loc,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data,
    input  logic [LOC_W-1:0] rd_loc,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    output logic             irq
);

    wr_req_t                    req;
    logic                       wr_owned;
    rsel_e                      wr_sel;
    logic [DW-1:0]              ev_bits;
    logic [NUM_LOC-1:0][DW-1:0] ien_all;
    logic [NUM_LOC-1:0][DW-1:0] ists_all;
    logic [NUM_LOC-1:0]         raise_vec;
    logic [NUM_LOC-1:0]         lower_vec;

    always_comb begin
        req      = '{en: wr_en, loc: wr_loc, off: wr_off, data: wr_data};
        wr_owned = req.en && act_vld && (req.loc == act_loc);
        wr_sel   = decode_off(req.off);
        ev_bits  = ev_to_sts(ev_mask);
    end

    for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
        logic mine_wr;
        logic mine_ev;
        assign mine_wr = wr_owned && (req.loc == LOC_W'(l));
        assign mine_ev = (ev_loc == LOC_W'(l));

        tis_irq_loc_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_ien  (mine_wr && (wr_sel == RSEL_IEN)),
            .wr_ists (mine_wr && (wr_sel == RSEL_ISTS)),
            .wr_data (req.data),
            .ev_bits (mine_ev ? ev_bits : '0),
            .ien_q   (ien_all[l]),
            .ists_q  (ists_all[l]),
            .raise   (raise_vec[l]),
            .lower   (lower_vec[l])
        );
    end

    tis_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
        .clk       (clk),
        .rst       (rst),
        .raise_vec (raise_vec),
        .lower_vec (lower_vec),
        .irq_q     (irq)
    );

    tis_irq_rd_mux #(.NUM_LOC(NUM_LOC), .IRQ_NUM(IRQ_NUM)) u_rd (
        .rd_loc   (rd_loc),
        .rd_off   (rd_off),
        .ien_all  (ien_all),
        .ists_all (ists_all),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/tis_irq_unit_chk.sv
module tis_irq_unit_chk
    import tis_irq_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned IRQ_NUM = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       act_vld,
    input logic [LOC_W-1:0]           act_loc,
    input logic                       wr_en,
    input logic [LOC_W-1:0]           wr_loc,
    input logic [OFF_W-1:0]           wr_off,
    input logic [LOC_W-1:0]           rd_loc,
    input logic [OFF_W-1:0]           rd_off,
    input logic [DW-1:0]              rd_data,
    input logic                       irq,
    input logic [NUM_LOC-1:0][DW-1:0] ien_all,
    input logic [NUM_LOC-1:0][DW-1:0] ists_all
);

    localparam logic [LOC_W-1:0] LOC_MAX = LOC_W'(NUM_LOC - 1);

    for (genvar l = 0; l < NUM_LOC; l++) begin : g_chk
        a_r2_latch_needs_global: assert property (@(posedge clk) disable iff (rst)
            ((ists_all[l] & ~$past(ists_all[l])) != '0) |-> $past(ien_all[l][GLOBAL_BIT]));

        a_r3_latch_raises_line: assert property (@(posedge clk) disable iff (rst)
            ((ists_all[l] & ~$past(ists_all[l])) != '0) |-> irq);
    end

    a_r5_foreign_write_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(act_vld && (wr_loc == act_loc))) |=> $stable(ien_all));

    a_r4_line_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en && (wr_off == OFF_ISTS)));

    a_r8_vector_constant: assert property (@(posedge clk) disable iff (rst)
        ((rd_off == OFF_IVEC) && (rd_loc <= LOC_MAX)) |-> (rd_data == DW'(IRQ_NUM)));

    a_r7_capability_constant: assert property (@(posedge clk) disable iff (rst)
        ((rd_off == OFF_ICAP) && (rd_loc <= LOC_MAX)) |-> (rd_data == CAP_VALUE));

endmodule

bind tis_irq_unit tis_irq_unit_chk #(.NUM_LOC(NUM_LOC), .IRQ_NUM(IRQ_NUM)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .act_vld  (act_vld),
    .act_loc  (act_loc),
    .wr_en    (wr_en),
    .wr_loc   (wr_loc),
    .wr_off   (wr_off),
    .rd_loc   (rd_loc),
    .rd_off   (rd_off),
    .rd_data  (rd_data),
    .irq      (irq),
    .ien_all  (ien_all),
    .ists_all (ists_all)
);

// File: tb/tis_irq_unit_tb.sv
module tis_irq_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_NUM    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_vld = 1'b0;
    logic [2:0]  act_loc = '0;
    logic [3:0]  ev_mask = '0;
    logic [2:0]  ev_loc = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_loc = '0;
    logic [7:0]  wr_off = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_loc = '0;
    logic [7:0]  rd_off = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tis_irq_unit #(.NUM_LOC(5), .IRQ_NUM(IRQ_NUM)) u_dut (
        .clk(clk), .rst(rst), .act_vld(act_vld), .act_loc(act_loc),
        .ev_mask(ev_mask), .ev_loc(ev_loc), .wr_en(wr_en), .wr_loc(wr_loc),
        .wr_off(wr_off), .wr_data(wr_data), .rd_loc(rd_loc), .rd_off(rd_off),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] loc, input logic [7:0] off, output logic [31:0] d);
        rd_loc = loc;
        rd_off = off;
        #1;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] loc, input logic [7:0] off,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(loc, off, d);
        chk(req, d, exp);
    endtask

    task automatic cyc(input bit do_wr, input logic [2:0] wl, input logic [7:0] wo,
                       input logic [31:0] wd, input logic [3:0] em, input logic [2:0] el);
        @(negedge clk);
        wr_en = do_wr; wr_loc = wl; wr_off = wo; wr_data = wd;
        ev_mask = em; ev_loc = el;
        @(negedge clk);
        wr_en = 1'b0; ev_mask = '0;
    endtask

    task automatic wr(input logic [2:0] l, input logic [7:0] o, input logic [31:0] d);
        cyc(1'b1, l, o, d, 4'h0, 3'd0);
    endtask

    task automatic ev(input logic [2:0] l, input logic [3:0] m);
        cyc(1'b0, 3'd0, 8'h00, 32'h0, m, l);
    endtask

    task automatic t_reset;
        for (int l = 0; l < 5; l++) begin
            rd_chk("R1 enable reset", 3'(l), 8'h08, 32'h0000_0008);
            rd_chk("R1 status reset", 3'(l), 8'h10, 32'h0);
        end
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_constants;
        rd_chk("R7 capability", 3'd2, 8'h14, 32'h2000_0697);
        rd_chk("R8 vector", 3'd4, 8'h0C, 32'(IRQ_NUM));
        act_vld = 1'b1; act_loc = 3'd4;
        wr(3'd4, 8'h0C, 32'h0000_000F);
        rd_chk("R8 vector after write", 3'd4, 8'h0C, 32'(IRQ_NUM));
        rd_chk("R9 unused offset", 3'd0, 8'h40, 32'hFFFF_FFFF);
        rd_chk("R9 unused offset 0x18", 3'd1, 8'h18, 32'hFFFF_FFFF);
        rd_chk("R9 locality out of range", 3'd6, 8'h08, 32'hFFFF_FFFF);
        act_vld = 1'b0;
    endtask

    task automatic t_ownership_and_mask;
        wr(3'd0, 8'h08, 32'h8000_0087);
        rd_chk("R5 no active locality", 3'd0, 8'h08, 32'h0000_0008);
        act_vld = 1'b1; act_loc = 3'd1;
        wr(3'd0, 8'h08, 32'h8000_0087);
        rd_chk("R5 foreign locality", 3'd0, 8'h08, 32'h0000_0008);
        wr(3'd1, 8'h08, 32'hFFFF_FFFF);
        rd_chk("R6 enable mask", 3'd1, 8'h08, 32'h8000_009F);
    endtask

    task automatic t_latching;
        ev(3'd1, 4'hF);
        rd_chk("R2 all events latched", 3'd1, 8'h10, 32'h0000_0087);
        chk("R3 irq raised", {31'h0, irq}, 32'h1);
        ev(3'd0, 4'hF);
        rd_chk("R2 disabled locality", 3'd0, 8'h10, 32'h0);
        wr(3'd1, 8'h10, 32'h0000_0087);
        chk("R4 irq lowered", {31'h0, irq}, 32'h0);
        wr(3'd1, 8'h08, 32'h8000_0001);
        ev(3'd1, 4'hF);
        rd_chk("R2 per-event enable", 3'd1, 8'h10, 32'h0000_0001);
        wr(3'd1, 8'h10, 32'h0000_0001);
        wr(3'd1, 8'h08, 32'h0000_0081);
        ev(3'd1, 4'hF);
        rd_chk("R2 global enable off", 3'd1, 8'h10, 32'h0);
        chk("R2 irq stays low", {31'h0, irq}, 32'h0);
        wr(3'd1, 8'h08, 32'h8000_0080);
        ev(3'd1, 4'h8);
        rd_chk("R2 command-ready to bit 7", 3'd1, 8'h10, 32'h0000_0080);
        wr(3'd1, 8'h10, 32'h0000_0080);
    endtask

    task automatic t_clearing;
        wr(3'd1, 8'h08, 32'h8000_0087);
        ev(3'd1, 4'hF);
        wr(3'd1, 8'h10, 32'h0000_0001);
        rd_chk("R4 partial clear", 3'd1, 8'h10, 32'h0000_0086);
        chk("R4 irq held on partial clear", {31'h0, irq}, 32'h1);
        act_loc = 3'd2;
        wr(3'd1, 8'h10, 32'h0000_0087);
        rd_chk("R5 foreign clear ignored", 3'd1, 8'h10, 32'h0000_0086);
        chk("R5 irq held", {31'h0, irq}, 32'h1);
        act_loc = 3'd1;
        wr(3'd1, 8'h10, 32'h0000_0086);
        rd_chk("R4 full clear", 3'd1, 8'h10, 32'h0);
        chk("R4 irq dropped", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_collision;
        ev(3'd1, 4'h1);
        cyc(1'b1, 3'd1, 8'h10, 32'h0000_0001, 4'h1, 3'd1);
        rd_chk("R10 set wins", 3'd1, 8'h10, 32'h0000_0001);
        chk("R10 irq held", {31'h0, irq}, 32'h1);
        wr(3'd1, 8'h10, 32'h0000_0001);
        chk("R4 irq after collision cleared", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_constants;
        t_ownership_and_mask;
        t_latching;
        t_clearing;
        t_collision;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule